// File: doc/BRIEF.md
# Dual-Enable Latched Bus Transceiver

This block is a 16-bit bus transceiver that stores data on its way between an A bus and a B bus, in either direction. The bits form two sections of eight lanes each, and the sections work independently. Each section has two paths, one from A to B and one from B to A. Each path has its own storage register and three active-low controls: a path enable, a latch enable and an output enable. A path is open while its path enable and its latch enable are both low. While it is open, the stored value tracks the source bus. When the path closes, because either of those two enables goes high, the source data present at that moment is kept. The path drives its far bus only while its path enable and its output enable are both low.

The design is synchronous. All controls and bus inputs are sampled on `clk`. Each bus appears as three vectors: the input data, the output data and a per-lane drive enable. A lane whose drive enable is deasserted stands for a released, high-impedance pin. The pad buffers outside the block combine the three vectors into the real bidirectional pins. For each section a flag reports when both of its directions would drive in the same cycle.

Top module: `xcvrDual`

## Requirements
- R1: Lane `s*8+i` of every bus vector belongs to section `s` (s = 0, 1). Activity on the controls or data of one section never changes the outputs of the other section.
- R2: When a path's enable and latch enable are both low at a clock edge, the path's stored value takes the source bus lanes at that edge. The far-bus output data shows this value from that edge onward.
- R3: At the first clock edge on which a previously open path is seen closed (its enable or its latch enable has risen), the stored value loads the source data present at that edge.
- R4: At a clock edge where a path is closed and was also closed at the previous edge, its stored value and its output data stay unchanged.
- R5: The per-lane drive enables of a path are all ones when its path enable and its output enable are both low, and all zeros otherwise. They follow the controls without a clock delay.
- R6: The B-to-A path obeys R2 to R5 with its own three controls, taking data from the B input and driving the A output vectors.
- R7: While `rstN` is low, every drive enable is zero. Reset clears all stored values to zero, and no capture happens at the first edge after reset.
- R8: `clash[s]` is high exactly when both paths of section `s` drive at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| aIn | input | 16 | Data received from the A bus |
| aOut | output | 16 | Data to place on the A bus (B-to-A path) |
| aOe | output | 16 | Per-lane drive enable for the A bus |
| bIn | input | 16 | Data received from the B bus |
| bOut | output | 16 | Data to place on the B bus (A-to-B path) |
| bOe | output | 16 | Per-lane drive enable for the B bus |
| enAbN | input | 2 | A-to-B path enable per section, active low |
| latAbN | input | 2 | A-to-B latch enable per section, active low |
| oeAbN | input | 2 | A-to-B output enable per section, active low |
| enBaN | input | 2 | B-to-A path enable per section, active low |
| latBaN | input | 2 | B-to-A latch enable per section, active low |
| oeBaN | input | 2 | B-to-A output enable per section, active low |
| clash | output | 2 | Per-section flag: both directions driving |

## Verification
The bench closes a path and changes the source data in the same cycle. A design that reads the data one edge late, or that never captures on closing, would then keep the wrong byte. It closes paths through the path enable as well as through the latch enable. A design that treated only the latch enable as a capture edge would fail there, as would one that left the output driving once the path enable was high. It also runs one section at random while the other holds a known byte. Crossed section slices would show up as that byte changing. Finally, it checks the drive enables and the stored values during and right after reset, which catches a design that starts with a spurious capture or with its outputs driving.

// File: rtl/xcvrPkg.sv
package xcvrPkg;

  // Strobes handed from a path controller to its storage slice
  typedef struct packed {
    logic load;   // store takes the source data at this edge
    logic drive;  // far bus lanes are driven
  } pathStrobe_t;

endpackage

// File: rtl/xcvrPathCtrl.sv
module xcvrPathCtrl
  import xcvrPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        enN,
  input  logic        latN,
  input  logic        oeN,
  output pathStrobe_t strb
);

  logic pathOpen;
  logic wasOpen;

  assign pathOpen = ~enN & ~latN;

  // Remember whether the path was open at the previous edge, so the
  // first closed edge can still capture.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wasOpen <= 1'b0;
    else       wasOpen <= pathOpen;
  end

  always_comb begin
    strb.load  = pathOpen | wasOpen;
    strb.drive = rstN & ~enN & ~oeN;
  end

endmodule

// File: rtl/xcvrPathData.sv
module xcvrPathData
  import xcvrPkg::*;
#(
  parameter int LANES = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  pathStrobe_t      strb,
  input  logic [LANES-1:0] din,
  output logic [LANES-1:0] dout,
  output logic [LANES-1:0] doe
);

  logic [LANES-1:0] store;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          store <= '0;
    else if (strb.load) store <= din;
  end

  assign dout = store;
  assign doe  = {LANES{strb.drive}};

endmodule

// File: rtl/xcvrDual.sv
module xcvrDual
  import xcvrPkg::*;
#(
  parameter int SECTIONS = 2,
  parameter int LANES    = 8,
  localparam int WIDTH   = SECTIONS * LANES
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [WIDTH-1:0]    aIn,
  output logic [WIDTH-1:0]    aOut,
  output logic [WIDTH-1:0]    aOe,
  input  logic [WIDTH-1:0]    bIn,
  output logic [WIDTH-1:0]    bOut,
  output logic [WIDTH-1:0]    bOe,
  input  logic [SECTIONS-1:0] enAbN,
  input  logic [SECTIONS-1:0] latAbN,
  input  logic [SECTIONS-1:0] oeAbN,
  input  logic [SECTIONS-1:0] enBaN,
  input  logic [SECTIONS-1:0] latBaN,
  input  logic [SECTIONS-1:0] oeBaN,
  output logic [SECTIONS-1:0] clash
);

  pathStrobe_t abStrb [SECTIONS];
  pathStrobe_t baStrb [SECTIONS];

  for (genvar s = 0; s < SECTIONS; s++) begin : gSect
    xcvrPathCtrl uAbCtrl (
      .clk(clk), .rstN(rstN),
      .enN(enAbN[s]), .latN(latAbN[s]), .oeN(oeAbN[s]),
      .strb(abStrb[s])
    );
    xcvrPathCtrl uBaCtrl (
      .clk(clk), .rstN(rstN),
      .enN(enBaN[s]), .latN(latBaN[s]), .oeN(oeBaN[s]),
      .strb(baStrb[s])
    );
    xcvrPathData #(.LANES(LANES)) uAbData (
      .clk(clk), .rstN(rstN), .strb(abStrb[s]),
      .din(aIn[s*LANES +: LANES]),
      .dout(bOut[s*LANES +: LANES]),
      .doe(bOe[s*LANES +: LANES])
    );
    xcvrPathData #(.LANES(LANES)) uBaData (
      .clk(clk), .rstN(rstN), .strb(baStrb[s]),
      .din(bIn[s*LANES +: LANES]),
      .dout(aOut[s*LANES +: LANES]),
      .doe(aOe[s*LANES +: LANES])
    );

    assign clash[s] = abStrb[s].drive & baStrb[s].drive;

    AST_AB_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
      (enAbN[s] | oeAbN[s]) |-> (bOe[s*LANES +: LANES] == '0)); // R5
    AST_BA_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
      (enBaN[s] | oeBaN[s]) |-> (aOe[s*LANES +: LANES] == '0)); // R6
    AST_AB_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
      (!enAbN[s] && !latAbN[s]) |=> (bOut[s*LANES +: LANES] == $past(aIn[s*LANES +: LANES]))); // R2
    AST_AB_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      ((enAbN[s] | latAbN[s]) && $past(enAbN[s] | latAbN[s])) |=> $stable(bOut[s*LANES +: LANES])); // R4
    AST_CLASH_FLAG: assert property (@(posedge clk) disable iff (!rstN)
      clash[s] |-> (aOe[s*LANES] && bOe[s*LANES])); // R8
  end

  always_comb begin
    if (!rstN) begin
      AST_RESET_RELEASE: assert ((aOe == '0) && (bOe == '0)); // R7
    end
  end

endmodule

// File: tb/sim_xcvrDual.sv
module sim_xcvrDual;

  localparam int SECT  = 2;
  localparam int LANES = 8;
  localparam int W     = SECT * LANES;

  logic clk = 1'b0;
  logic rstN;
  logic [W-1:0] aIn, bIn, aOut, aOe, bOut, bOe;
  logic [SECT-1:0] enAbN, latAbN, oeAbN, enBaN, latBaN, oeBaN, clash;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // reference state
  logic [7:0] refAb [SECT];
  logic [7:0] refBa [SECT];
  bit openAbPrev [SECT];
  bit openBaPrev [SECT];
  string tagAb [SECT];
  string tagBa [SECT];

  always #5 clk = ~clk;

  xcvrDual u0 (
    .clk(clk), .rstN(rstN), .aIn(aIn), .aOut(aOut), .aOe(aOe),
    .bIn(bIn), .bOut(bOut), .bOe(bOe),
    .enAbN(enAbN), .latAbN(latAbN), .oeAbN(oeAbN),
    .enBaN(enBaN), .latBaN(latBaN), .oeBaN(oeBaN), .clash(clash)
  );

  // Behavioural model: update at each clock edge from the sampled inputs
  always @(posedge clk or negedge rstN) begin
    for (int s = 0; s < SECT; s++) begin
      if (!rstN) begin
        refAb[s] = 8'h00; refBa[s] = 8'h00;
        openAbPrev[s] = 0; openBaPrev[s] = 0;
        tagAb[s] = "R7"; tagBa[s] = "R7";
      end else begin
        bit nowAb, nowBa;
        nowAb = !enAbN[s] && !latAbN[s];
        nowBa = !enBaN[s] && !latBaN[s];
        if (nowAb) begin refAb[s] = aIn[s*8 +: 8]; tagAb[s] = "R2"; end
        else if (openAbPrev[s]) begin refAb[s] = aIn[s*8 +: 8]; tagAb[s] = "R3"; end
        else tagAb[s] = "R4";
        if (nowBa) begin refBa[s] = bIn[s*8 +: 8]; tagBa[s] = "R6/R2"; end
        else if (openBaPrev[s]) begin refBa[s] = bIn[s*8 +: 8]; tagBa[s] = "R6/R3"; end
        else tagBa[s] = "R6/R4";
        openAbPrev[s] = nowAb;
        openBaPrev[s] = nowBa;
      end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll(string phase);
    for (int s = 0; s < SECT; s++) begin
      bit dAb, dBa;
      dAb = rstN && !enAbN[s] && !oeAbN[s];
      dBa = rstN && !enBaN[s] && !oeBaN[s];
      check({phase, " ", tagAb[s], " bOut"}, 32'(bOut[s*8 +: 8]), 32'(refAb[s]));
      check({phase, " ", tagBa[s], " aOut"}, 32'(aOut[s*8 +: 8]), 32'(refBa[s]));
      check({phase, rstN ? " R5 bOe" : " R7 bOe"}, 32'(bOe[s*8 +: 8]), dAb ? 32'hFF : 32'h0);
      check({phase, rstN ? " R6/R5 aOe" : " R7 aOe"}, 32'(aOe[s*8 +: 8]), dBa ? 32'hFF : 32'h0);
      check({phase, " R8 clash"}, 32'(clash[s]), 32'(dAb && dBa));
    end
  endtask

  task automatic step(string phase);
    @(posedge clk);
    @(negedge clk);
    compareAll(phase);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    aIn = '0; bIn = '0;
    enAbN = '1; latAbN = '1; oeAbN = '1;
    enBaN = '1; latBaN = '1; oeBaN = '1;
    #1;
    // drive enables during reset with output enables low
    enAbN = '0; oeAbN = '0; enBaN = '0; oeBaN = '0;
    aIn = 16'hFFFF; bIn = 16'hFFFF;
    repeat (2) step("reset R7");
    check("R7 reset release", 32'(aOe | bOe), 32'h0);
    @(negedge clk);
    enAbN = '1; oeAbN = '1; enBaN = '1; oeBaN = '1;
    rstN = 1'b1;
    step("post-reset R7");
    check("R7 cleared store", 32'(bOut), 32'h0);

    // section 0 A-to-B transparent
    enAbN[0] = 0; latAbN[0] = 0; oeAbN[0] = 0; aIn[7:0] = 8'h5A;
    step("transparent");
    check("R2 follow 5A", 32'(bOut[7:0]), 32'h5A);
    aIn[7:0] = 8'hC3;
    step("transparent");
    check("R2 follow C3", 32'(bOut[7:0]), 32'hC3);
    // close through latch enable with new data at the same time
    latAbN[0] = 1; aIn[7:0] = 8'h77;
    step("close-lat");
    check("R3 capture 77", 32'(bOut[7:0]), 32'h77);
    check("R5 drive while latched", 32'(bOe[7:0]), 32'hFF);
    aIn[7:0] = 8'h11;
    step("hold"); step("hold");
    check("R4 hold 77", 32'(bOut[7:0]), 32'h77);
    oeAbN[0] = 1;
    #1 check("R5 release on oe", 32'(bOe[7:0]), 32'h0);
    step("oe-off");
    // close through path enable
    oeAbN[0] = 0; latAbN[0] = 0; aIn[7:0] = 8'h22;
    step("reopen");
    enAbN[0] = 1; aIn[7:0] = 8'h99;
    #1 check("R5 release on enable", 32'(bOe[7:0]), 32'h0);
    step("close-en");
    check("R3 capture 99 via enable", 32'(bOut[7:0]), 32'h99);
    aIn[7:0] = 8'h00;
    step("hold");
    check("R4 hold 99", 32'(bOut[7:0]), 32'h99);

    // section 1 B-to-A
    enBaN[1] = 0; latBaN[1] = 0; oeBaN[1] = 0; bIn[15:8] = 8'hA5;
    step("ba-open");
    check("R6 B-to-A follow", 32'(aOut[15:8]), 32'hA5);
    check("R6 aOe lanes", 32'(aOe), 32'hFF00);
    latBaN[1] = 1; bIn[15:8] = 8'h3C;
    step("ba-close");
    check("R6 B-to-A capture", 32'(aOut[15:8]), 32'h3C);
    // both directions of section 1 drive
    enAbN[1] = 0; oeAbN[1] = 0; latAbN[1] = 1;
    #1 check("R8 clash section 1", 32'(clash), 32'h2);
    step("clash");

    // section 0 held, section 1 random
    enAbN[0] = 1; latAbN[0] = 1; oeAbN[0] = 0;
    enBaN[0] = 1; latBaN[0] = 1; oeBaN[0] = 1;
    for (int i = 0; i < 300; i++) begin
      {enAbN[1], latAbN[1], oeAbN[1], enBaN[1], latBaN[1], oeBaN[1]} = 6'($urandom);
      aIn = 16'($urandom); bIn = 16'($urandom);
      step("R1 isolation");
    end
    check("R1 section 0 unchanged", 32'(bOut[7:0]), 32'h99);

    // fully random traffic
    for (int i = 0; i < 3000; i++) begin
      for (int s = 0; s < SECT; s++) begin
        enAbN[s]  = ($urandom % 4) == 0;
        latAbN[s] = ($urandom % 3) == 0;
        oeAbN[s]  = ($urandom % 4) == 0;
        enBaN[s]  = ($urandom % 4) == 0;
        latBaN[s] = ($urandom % 3) == 0;
        oeBaN[s]  = ($urandom % 4) == 0;
      end
      aIn = 16'($urandom); bIn = 16'($urandom);
      step("random");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule